// File: doc/BRIEF.md
# Dual Lookup Table DAC Router

This block takes an 8-bit sample from a converter and turns it into the input codes for two DACs. Each DAC channel has its own 64-row by 8-bit lookup table. The upper six bits of the sample pick a row, and that row's byte goes to the DAC. The tables let the chip shape a sensor's response curve before it reaches the analog outputs. The sample code runs from all zeros at minimum input to all ones at full scale.

Each channel has two bypasses that work independently of each other. The row bypass replaces the sample-derived row with a forced 6-bit row index. The source bypass replaces the table byte with a raw 8-bit value. With these, any of three data sources can reach a DAC: a row chosen by the sample, a forced row, or a literal code. The same row can be forced while the table is rewritten, for calibration, or the DAC can be pinned to a value during bring-up.

The bypass selects and the forced row and value are held in internal registers, written through a small configuration port. The tables are loaded through a separate write port. Both DAC codes leave the block from registers.

Top module: `lut_dac_router`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both DAC outputs become 0, and every select, forced row and forced value clears to 0. After reset, each channel therefore drives its table row 0, which is the row of the cleared sample.
- R2: A rising edge with `smp_valid` high captures `smp_data`. With both bypasses off, each channel's output on the next edge is its table byte at row `smp_data[7:2]`.
- R3: A rising edge with `smp_valid` low leaves the captured sample unchanged, whatever `smp_data` carries.
- R4: Configuration field code 0 writes the row bypass from data bit 0. Field code 2 writes the forced row from data bits 5:0. While the row bypass is 1, the channel's table is read at the forced row and the sample does not affect that channel.
- R5: Field code 1 writes the source bypass from data bit 0. Field code 3 writes the forced value from all 8 data bits. While the source bypass is 1, the channel outputs the forced value, and neither table contents nor the addressed row affect it.
- R6: While the source bypass is 0, the forced value has no effect on the channel's output.
- R7: `cfg_chan` and `tbl_chan` (0 or 1) select the channel that a configuration or table write touches. The other channel's state and output are unchanged.
- R8: A table write at edge E to the row a channel is reading shows on that channel's output at edge E+1, and not at edge E.
- R9: A configuration write at edge E changes the output at edge E+1, and not at edge E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Strobe that captures a new sample |
| smp_data | input | 8 | Converter sample code |
| cfg_we | input | 1 | Configuration write enable |
| cfg_chan | input | 1 | Channel addressed by the configuration write |
| cfg_field | input | 2 | Field code: 0 row bypass, 1 source bypass, 2 forced row, 3 forced value |
| cfg_data | input | 8 | Configuration write data |
| tbl_we | input | 1 | Table write enable |
| tbl_chan | input | 1 | Channel whose table is written |
| tbl_row | input | 6 | Table row written |
| tbl_data | input | 8 | Table byte written |
| dac_out | output | 2x8 | Registered DAC codes, index 0 is channel 0 |

## Verification
The hardest case to reach is a bypassed channel that must stay still while everything it normally depends on is changing. This means table writes landing on the very row the channel would read, new samples arriving, and the other channel being reprogrammed in the same cycle. The bench reaches this case in two ways. Directed sequences first force a row, then rewrite exactly that row with the source bypass both on and off. A long random phase then fires sample strobes, configuration writes and table writes together in single cycles. Every cycle is compared against a cycle-accurate model of the two-edge pipeline.

// File: rtl/lut_dac_pkg.sv
package lut_dac_pkg;

    localparam int NCH_DEF   = 2;
    localparam int SMP_W_DEF = 8;
    localparam int ROW_W_DEF = 6;
    localparam int DAT_W_DEF = 8;

    typedef enum logic [1:0] {
        FLD_ROW_BYP = 2'd0,
        FLD_SRC_BYP = 2'd1,
        FLD_ROW_IDX = 2'd2,
        FLD_VAL     = 2'd3
    } cfg_field_e;

endpackage

// File: rtl/lut_dac_table.sv
module lut_dac_table #(
    parameter int ROW_W = 6,
    parameter int DAT_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [DAT_W-1:0] wr_byte,
    input  logic [ROW_W-1:0] rd_row,
    output logic [DAT_W-1:0] rd_byte
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DAT_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_row] <= wr_byte;
        end
    end

    // Asynchronous read: the byte feeds the output register directly.
    assign rd_byte = mem_q[rd_row];

endmodule

// File: rtl/lut_dac_cfg.sv
module lut_dac_cfg
    import lut_dac_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int ROW_W = 6,
    parameter int DAT_W = 8,
    parameter int CH_W  = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [CH_W-1:0]                 cfg_chan,
    input  logic [1:0]                      cfg_field,
    input  logic [DAT_W-1:0]                cfg_data,
    output logic [NCH-1:0]                  row_byp,
    output logic [NCH-1:0]                  src_byp,
    output logic [NCH-1:0][ROW_W-1:0]       frc_row,
    output logic [NCH-1:0][DAT_W-1:0]       frc_val
);
    typedef struct packed {
        logic [NCH-1:0]            row_byp;
        logic [NCH-1:0]            src_byp;
        logic [NCH-1:0][ROW_W-1:0] frc_row;
        logic [NCH-1:0][DAT_W-1:0] frc_val;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int c = 0; c < NCH; c++) begin
                if (cfg_chan == CH_W'(c)) begin
                    unique case (cfg_field_e'(cfg_field))
                        FLD_ROW_BYP: st_d.row_byp[c] = cfg_data[0];
                        FLD_SRC_BYP: st_d.src_byp[c] = cfg_data[0];
                        FLD_ROW_IDX: st_d.frc_row[c] = cfg_data[ROW_W-1:0];
                        FLD_VAL:     st_d.frc_val[c] = cfg_data;
                        default:     st_d = st_q;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_byp = st_q.row_byp;
    assign src_byp = st_q.src_byp;
    assign frc_row = st_q.frc_row;
    assign frc_val = st_q.frc_val;

endmodule

// File: rtl/lut_dac_path.sv
module lut_dac_path #(
    parameter int ROW_W = 6,
    parameter int DAT_W = 8
) (
    input  logic [ROW_W-1:0] smp_row,
    input  logic             row_byp,
    input  logic             src_byp,
    input  logic [ROW_W-1:0] frc_row,
    input  logic [DAT_W-1:0] frc_val,
    input  logic [DAT_W-1:0] tbl_byte,
    output logic [ROW_W-1:0] rd_row,
    output logic [DAT_W-1:0] dac_nxt
);
    always_comb begin
        rd_row  = row_byp ? frc_row : smp_row;
        dac_nxt = src_byp ? frc_val : tbl_byte;
    end

endmodule

// File: rtl/lut_dac_router.sv
module lut_dac_router
    import lut_dac_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int SMP_W = SMP_W_DEF,
    parameter int ROW_W = ROW_W_DEF,
    parameter int DAT_W = DAT_W_DEF,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_valid,
    input  logic [SMP_W-1:0]          smp_data,
    input  logic                      cfg_we,
    input  logic [CH_W-1:0]           cfg_chan,
    input  logic [1:0]                cfg_field,
    input  logic [DAT_W-1:0]          cfg_data,
    input  logic                      tbl_we,
    input  logic [CH_W-1:0]           tbl_chan,
    input  logic [ROW_W-1:0]          tbl_row,
    input  logic [DAT_W-1:0]          tbl_data,
    output logic [NCH-1:0][DAT_W-1:0] dac_out
);
    localparam int LOW_W = SMP_W - ROW_W;

    typedef struct packed {
        logic [ROW_W-1:0]            smp_row;
        logic [NCH-1:0][DAT_W-1:0]   dac;
    } top_state_t;

    top_state_t st_d, st_q;

    // Only the upper bits select a row; the rest are deliberately dropped.
    logic smp_unused;
    assign smp_unused = ^smp_data[LOW_W-1:0];

    logic [NCH-1:0]            row_byp;
    logic [NCH-1:0]            src_byp;
    logic [NCH-1:0][ROW_W-1:0] frc_row;
    logic [NCH-1:0][DAT_W-1:0] frc_val;
    logic [NCH-1:0][ROW_W-1:0] rd_row;
    logic [NCH-1:0][DAT_W-1:0] tbl_rd;
    logic [NCH-1:0][DAT_W-1:0] dac_nxt;
    logic [ROW_W-1:0]          smp_row_q;

    lut_dac_cfg #(
        .NCH   (NCH),
        .ROW_W (ROW_W),
        .DAT_W (DAT_W),
        .CH_W  (CH_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_chan  (cfg_chan),
        .cfg_field (cfg_field),
        .cfg_data  (cfg_data),
        .row_byp   (row_byp),
        .src_byp   (src_byp),
        .frc_row   (frc_row),
        .frc_val   (frc_val)
    );

    assign smp_row_q = st_q.smp_row;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic wr_hit;
        assign wr_hit = tbl_we && (tbl_chan == CH_W'(c));

        lut_dac_table #(
            .ROW_W (ROW_W),
            .DAT_W (DAT_W)
        ) tbl_i (
            .clk     (clk),
            .wr_en   (wr_hit),
            .wr_row  (tbl_row),
            .wr_byte (tbl_data),
            .rd_row  (rd_row[c]),
            .rd_byte (tbl_rd[c])
        );

        lut_dac_path #(
            .ROW_W (ROW_W),
            .DAT_W (DAT_W)
        ) path_i (
            .smp_row  (smp_row_q),
            .row_byp  (row_byp[c]),
            .src_byp  (src_byp[c]),
            .frc_row  (frc_row[c]),
            .frc_val  (frc_val[c]),
            .tbl_byte (tbl_rd[c]),
            .rd_row   (rd_row[c]),
            .dac_nxt  (dac_nxt[c])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.dac = dac_nxt;
        if (smp_valid) begin
            st_d.smp_row = smp_data[SMP_W-1 -: ROW_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_out = st_q.dac;

endmodule

// File: rtl/lut_dac_router_chk.sv
module lut_dac_router_chk #(
    parameter int NCH   = 2,
    parameter int SMP_W = 8,
    parameter int ROW_W = 6,
    parameter int DAT_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      smp_valid,
    input logic [SMP_W-1:0]          smp_data,
    input logic [ROW_W-1:0]          smp_row_q,
    input logic [NCH-1:0]            src_byp,
    input logic [NCH-1:0][DAT_W-1:0] frc_val,
    input logic [NCH-1:0][DAT_W-1:0] tbl_rd,
    input logic [NCH-1:0][DAT_W-1:0] dac_out
);
    logic rst_low_seen = 1'b0;

    always @(posedge clk) begin
        if (rst_low_seen) begin
            AST_RESET_ZERO: assert (dac_out == '0); // R1
        end
        rst_low_seen <= !rst_n;
    end

    AST_SMP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> smp_row_q == $past(smp_data[SMP_W-1 -: ROW_W])); // R2

    AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(smp_row_q)); // R3

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_FORCED_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            src_byp[c] |=> dac_out[c] == $past(frc_val[c])); // R5

        AST_TABLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            !src_byp[c] |=> dac_out[c] == $past(tbl_rd[c])); // R6
    end

endmodule

bind lut_dac_router lut_dac_router_chk #(
    .NCH   (NCH),
    .SMP_W (SMP_W),
    .ROW_W (ROW_W),
    .DAT_W (DAT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_row_q (smp_row_q),
    .src_byp   (src_byp),
    .frc_val   (frc_val),
    .tbl_rd    (tbl_rd),
    .dac_out   (dac_out)
);

// File: tb/lut_dac_router_tb.sv
module lut_dac_router_tb_top;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             smp_valid;
    logic [7:0]       smp_data;
    logic             cfg_we;
    logic [0:0]       cfg_chan;
    logic [1:0]       cfg_field;
    logic [7:0]       cfg_data;
    logic             tbl_we;
    logic [0:0]       tbl_chan;
    logic [5:0]       tbl_row;
    logic [7:0]       tbl_data;
    logic [1:0][7:0]  dac_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit armed  = 1'b0;

    // Reference model state
    logic [7:0] m_tbl [2][64];
    logic       m_rbyp [2];
    logic       m_sbyp [2];
    logic [5:0] m_row  [2];
    logic [7:0] m_val  [2];
    logic [7:0] m_smp;
    logic [7:0] exp_out [2];
    string      exp_tag [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_dac_router dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .cfg_we    (cfg_we),
        .cfg_chan  (cfg_chan),
        .cfg_field (cfg_field),
        .cfg_data  (cfg_data),
        .tbl_we    (tbl_we),
        .tbl_chan  (tbl_chan),
        .tbl_row   (tbl_row),
        .tbl_data  (tbl_data),
        .dac_out   (dac_out)
    );

    function automatic logic [7:0] model_out(int c);
        logic [5:0] r;
        r = m_rbyp[c] ? m_row[c] : m_smp[7:2];
        return m_sbyp[c] ? m_val[c] : m_tbl[c][r];
    endfunction

    function automatic string model_tag(int c);
        if (m_sbyp[c]) return "R5";
        if (m_rbyp[c]) return "R4";
        return "R2";
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        smp_valid = 1'b0;
        cfg_we    = 1'b0;
        tbl_we    = 1'b0;
    endtask

    // One clock: predict from pre-edge model, apply driven inputs to model, check.
    task automatic tick(string tag);
        logic [7:0] e [2];
        string      t [2];
        for (int c = 0; c < 2; c++) begin
            e[c] = model_out(c);
            t[c] = (tag == "") ? model_tag(c) : tag;
        end
        if (smp_valid) m_smp = smp_data;
        if (cfg_we) begin
            case (cfg_field)
                2'd0: m_rbyp[cfg_chan] = cfg_data[0];
                2'd1: m_sbyp[cfg_chan] = cfg_data[0];
                2'd2: m_row[cfg_chan]  = cfg_data[5:0];
                default: m_val[cfg_chan] = cfg_data;
            endcase
        end
        if (tbl_we) m_tbl[tbl_chan][tbl_row] = tbl_data;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        for (int c = 0; c < 2; c++) begin
            exp_out[c] = e[c];
            exp_tag[c] = t[c];
            if (armed) check(t[c], dac_out[c], e[c], $sformatf("ch%0d", c));
        end
    endtask

    task automatic cfg_wr(int ch, int fld, logic [7:0] d, string tag);
        cfg_we = 1'b1; cfg_chan = 1'(ch); cfg_field = 2'(fld); cfg_data = d;
        tick(tag);
    endtask

    task automatic tbl_wr(int ch, int row, logic [7:0] d, string tag);
        tbl_we = 1'b1; tbl_chan = 1'(ch); tbl_row = 6'(row); tbl_data = d;
        tick(tag);
    endtask

    task automatic smp_in(logic [7:0] d, string tag);
        smp_valid = 1'b1; smp_data = d;
        tick(tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0;
        idle_inputs();
        smp_data = 8'h00; cfg_chan = '0; cfg_field = '0; cfg_data = '0;
        tbl_chan = '0; tbl_row = '0; tbl_data = '0;
        for (int c = 0; c < 2; c++) begin
            m_rbyp[c] = 0; m_sbyp[c] = 0; m_row[c] = 0; m_val[c] = 0;
        end
        m_smp = 8'h00;
        @(negedge clk);
        // R1: reset drives zeros, even with inputs toggling
        for (int i = 0; i < 4; i++) begin
            smp_valid = 1'b1; smp_data = 8'hFF;
            cfg_we = 1'b1; cfg_field = 2'd3; cfg_data = 8'hAA;
            @(posedge clk); @(negedge clk);
            check("R1", dac_out[0], 8'h00, "ch0 in reset");
            check("R1", dac_out[1], 8'h00, "ch1 in reset");
        end
        idle_inputs();
        rst_n = 1'b1;
        // Load both tables (unchecked)
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 64; r++)
                tbl_wr(c, r, 8'((r * 7 + c * 101 + 3) & 8'hFF), "load");
        armed = 1'b1;
        // R1: defaults route sample row 0 from the table
        tick("R1");
        tick("R1");

        // R2: sample extremes and midpoint
        smp_in(8'hFF, "R2"); tick("R2");
        smp_in(8'h80, "R2"); tick("R2");
        smp_in(8'h03, "R2"); tick("R2");
        smp_in(8'h7C, "R2"); tick("R2");

        // R3: data toggles with no strobe
        smp_data = 8'hC4; tick("R3");
        smp_data = 8'h10; tick("R3");

        // R9 and R4: row bypass on channel 0; output moves one edge late
        cfg_wr(0, 2, 8'hE5, "R9");
        cfg_wr(0, 0, 8'h01, "R9");
        tick("R4");
        smp_in(8'h44, "R4"); tick("R4");

        // R8: rewrite the forced row of channel 0
        tbl_wr(0, 37, 8'h5A, "R8");
        tick("R8");

        // R6: forced value ignored while source bypass is 0
        cfg_wr(0, 3, 8'hC3, "R6");
        tick("R6");
        cfg_wr(1, 3, 8'h3C, "R6");
        tick("R6");

        // R5: source bypass; table writes on read row ignored
        cfg_wr(0, 1, 8'h01, "R9");
        tick("R5");
        tbl_wr(0, 37, 8'hA5, "R5");
        tick("R5");
        smp_in(8'h00, "R5"); tick("R5");

        // R7: channel 1 writes leave channel 0 untouched
        cfg_wr(1, 0, 8'h01, "R7");
        cfg_wr(1, 2, 8'h09, "R7");
        tbl_wr(1, 37, 8'h11, "R7");
        tick("R7");
        cfg_wr(0, 1, 8'h00, "R7");
        tick("R7");
        cfg_wr(0, 0, 8'h00, "R7");
        cfg_wr(1, 0, 8'h00, "R7");
        tick("R7");

        // Random mixed traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(1, 0) == 1) begin
                smp_valid = 1'b1; smp_data = 8'($urandom());
            end else begin
                smp_data = 8'($urandom());
            end
            if ($urandom_range(3, 0) == 0) begin
                cfg_we = 1'b1; cfg_chan = 1'($urandom()); cfg_field = 2'($urandom());
                cfg_data = 8'($urandom());
            end
            if ($urandom_range(2, 0) == 0) begin
                tbl_we = 1'b1; tbl_chan = 1'($urandom()); tbl_row = 6'($urandom());
                tbl_data = 8'($urandom());
            end
            tick("");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule